// File: doc/BRIEF.md
# Fixed-Point Neural Predistorter Inference Core

This core runs one inference of a small real-valued perceptron network that predistorts a baseband signal before it reaches a power amplifier. A host or upstream stage presents a feature vector of N signed Q1.15 values, such as current and delayed I/Q samples, together with a one-cycle start strobe. The core then evaluates H hidden neurons with a rectifying activation, followed by two linear output neurons. It returns the predistorted in-phase and quadrature samples along with a one-cycle completion pulse.

Every multiply-accumulate goes through one shared multiplier. Neurons are processed one at a time, and each takes as many cycles as it has inputs. The network is trained offline. Its coefficients are loaded unchanged through a single-word write port into an internal register file, and the core never adapts them. While a run is in progress the core raises `busy`. During that time it drops both start strobes and coefficient writes, so the host must check `busy` before it writes.

All arithmetic is signed two's complement. Products accumulate in a wide accumulator. At every neuron output the sum is rounded and saturated back to 16 bits.

Top module: `mlp_dpd_core`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_i` and `out_q` are 0, and every coefficient is 0, so a run made without any writes returns 0 on both outputs.
- R2: Coefficient map, one 16-bit word per address. Hidden weight for neuron h and input n is at h*N+n. Hidden bias h is at H*N+h. Output weight for output o and hidden neuron h is at H*N+H+o*H+h, where o=0 is I and o=1 is Q. Output bias o is at H*N+3H+o. A write to an address of H*N+3H+2 or above changes nothing.
- R3: Hidden neuron h yields max(0, S(b*2^15 + sum of w*x)). S adds 2^14, shifts arithmetically right by 15 (round half up) and saturates. Feature n occupies `in_feat[16n+15:16n]`.
- R4: The two output neurons use the same S on the hidden values with no activation, so negative results pass through. `out_i` comes from output 0 and `out_q` from output 1.
- R5: S clamps every neuron result to the range -32768 to 32767.
- R6: `in_valid` while idle starts a run, and `busy` is high from the next cycle. After exactly H*N+2H clock edges, `out_valid` is high for one cycle with both outputs updated and `busy` already low.
- R7: `in_valid` while `busy` is high is ignored. The running result is unaffected and no extra run follows.
- R8: `wr_en` while `busy` is high is ignored, both for the current run and for later runs. When `in_valid` and `wr_en` arrive together while idle, the run starts and the write is dropped.
- R9: `out_i` and `out_q` hold their values between completion pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Start strobe for one inference |
| in_feat | input | N*16 | Packed feature vector, feature n in bits 16n+15:16n |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | clog2(H*N+3H+3) | Coefficient address |
| wr_data | input | 16 | Coefficient value, Q1.15 |
| busy | output | 1 | Run in progress; starts and writes are dropped |
| out_valid | output | 1 | One-cycle pulse when both outputs are ready |
| out_i | output | 16 | Predistorted in-phase sample, Q1.15 |
| out_q | output | 16 | Predistorted quadrature sample, Q1.15 |

## Verification
The core is tried with several kinds of network. A network made of biases only, with one path lit, proves the coefficient map and the I/Q assignment. A network with one negative hidden bias separates the rectified hidden layer from the linear output layer. A single product of exactly half an LSB shows that rounding goes up rather than truncating. Full-scale weights and features, with both signs, drive every neuron into the clamp. Long sweeps of random coefficients and features, in full-range and attenuated sets, are compared bit for bit with an arithmetic model. Further runs inject a start strobe or a write mid-run to show both are dropped, and also measure the latency and how long the outputs hold.

// File: rtl/mlp_dpd_core.sv
`timescale 1ns/1ps
module mlp_dpd_core #(
  parameter int N = 16,
  parameter int H = 8,
  parameter int W = 16,
  parameter int ACCW = 40,
  localparam int AW = $clog2(H*N + 3*H + 3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_feat,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  output logic           busy,
  output logic           out_valid,
  output logic [W-1:0]   out_i,
  output logic [W-1:0]   out_q
);
  localparam int HB    = H*N;
  localparam int WO    = HB + H;
  localparam int OB    = WO + 2*H;
  localparam int TOTAL = OB + 2;
  localparam int FR    = W - 1;
  localparam int NH    = (N > H) ? N : H;
  localparam int KW    = $clog2(NH + 1);
  localparam int NW    = $clog2(H + 1);
  localparam int LAT   = H*N + 2*H;
  localparam int CW    = $clog2(LAT + 1);

  logic [W-1:0]    coef [TOTAL];
  logic [W-1:0]    feat [N];
  logic [W-1:0]    hid  [H];
  logic [ACCW-1:0] acc;
  logic            layer;
  logic [NW-1:0]   neu;
  logic [KW-1:0]   k;
  logic [W-1:0]    res_i;

  function automatic logic [W-1:0] rd(input logic [AW-1:0] a);
    logic [W-1:0] v;
    v = '0;
    for (int i = 0; i < TOTAL; i++)
      if (a == AW'(i)) v = coef[i];
    return v;
  endfunction

  function automatic logic [ACCW-1:0] bias_ext(input logic [W-1:0] b);
    return {{(ACCW-W-FR){b[W-1]}}, b, {FR{1'b0}}};
  endfunction

  function automatic logic [W-1:0] rnd_sat(input logic [ACCW-1:0] a);
    logic signed [ACCW-1:0] s;
    s = $signed(a + {{(ACCW-FR){1'b0}}, 1'b1, {(FR-1){1'b0}}});
    s = s >>> FR;
    if (s[ACCW-1:W-1] != {(ACCW-W+1){s[W-1]}})
      return s[ACCW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    return s[W-1:0];
  endfunction

  logic [AW-1:0]     wa, nb_addr;
  logic [W-1:0]      cw, cx, fsel, hsel, nbias, bias0, r_v, relu_v;
  logic [2*W-1:0]    prod;
  logic [ACCW-1:0]   acc_nx;
  logic              last_k, last_neu;

  always_comb begin
    fsel = '0;
    for (int i = 0; i < N; i++)
      if (k == KW'(i)) fsel = feat[i];
    hsel = '0;
    for (int i = 0; i < H; i++)
      if (k == KW'(i)) hsel = hid[i];
    cx = layer ? hsel : fsel;
    if (!layer) wa = AW'(int'(neu)*N + int'(k));
    else        wa = AW'(WO + int'(neu)*H + int'(k));
    cw = rd(wa);
    last_k   = layer ? (k == KW'(H-1)) : (k == KW'(N-1));
    last_neu = layer ? (neu == NW'(1)) : (neu == NW'(H-1));
    if (!layer) nb_addr = last_neu ? AW'(OB) : AW'(HB + int'(neu) + 1);
    else        nb_addr = AW'(OB + 1);
    nbias = rd(nb_addr);
    bias0 = rd(AW'(HB));
  end

  assign prod   = $signed({{W{cw[W-1]}}, cw}) * $signed({{W{cx[W-1]}}, cx});
  assign acc_nx = acc + {{(ACCW-2*W){prod[2*W-1]}}, prod};
  assign r_v    = rnd_sat(acc_nx);
  assign relu_v = r_v[W-1] ? '0 : r_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) coef[i] <= '0;
      for (int i = 0; i < N; i++) feat[i] <= '0;
      for (int i = 0; i < H; i++) hid[i] <= '0;
      acc       <= '0;
      busy      <= 1'b0;
      layer     <= 1'b0;
      neu       <= '0;
      k         <= '0;
      res_i     <= '0;
      out_i     <= '0;
      out_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          for (int i = 0; i < N; i++) feat[i] <= in_feat[i*W +: W];
          acc   <= bias_ext(bias0);
          busy  <= 1'b1;
          layer <= 1'b0;
          neu   <= '0;
          k     <= '0;
        end else if (wr_en) begin
          for (int i = 0; i < TOTAL; i++)
            if (wr_addr == AW'(i)) coef[i] <= wr_data;
        end
      end else if (!last_k) begin
        acc <= acc_nx;
        k   <= k + KW'(1);
      end else begin
        acc <= bias_ext(nbias);
        k   <= '0;
        if (!layer) begin
          for (int i = 0; i < H; i++)
            if (neu == NW'(i)) hid[i] <= relu_v;
          if (last_neu) begin
            layer <= 1'b1;
            neu   <= '0;
          end else begin
            neu <= neu + NW'(1);
          end
        end else if (!last_neu) begin
          res_i <= r_v;
          neu   <= neu + NW'(1);
        end else begin
          out_i     <= res_i;
          out_q     <= r_v;
          out_valid <= 1'b1;
          busy      <= 1'b0;
        end
      end
    end
  end

  logic [CW-1:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + CW'(1);
    else           bcnt <= '0;
  end

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> bcnt == CW'(LAT));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy);
  // R7
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid));
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));
endmodule

// File: tb/test_mlp_dpd_core.sv
`timescale 1ns/1ps
module test_mlp_dpd_core;
  localparam int N = 4;
  localparam int H = 2;
  localparam int HB = H*N;
  localparam int WO = HB + H;
  localparam int OB = WO + 2*H;
  localparam int TOTAL = OB + 2;
  localparam int AW = $clog2(H*N + 3*H + 3);
  localparam int LAT = H*N + 2*H;

  logic clk = 0, rst_n = 0, in_valid = 0, wr_en = 0;
  logic [N*16-1:0] in_feat = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic busy, out_valid;
  logic [15:0] out_i, out_q;

  mlp_dpd_core #(.N(N), .H(H)) i_mlp_dpd_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_feat(in_feat),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  logic signed [15:0] mc [TOTAL];
  logic signed [15:0] fv [N];
  logic signed [15:0] ei, eq;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] sat16(input longint a);
    longint t;
    t = (a + 64'sd16384) >>> 15;
    if (t > 32767) t = 32767;
    else if (t < -32768) t = -32768;
    return 16'(t);
  endfunction

  task automatic model();
    logic signed [15:0] hv [H];
    longint a;
    for (int h = 0; h < H; h++) begin
      a = longint'(mc[HB+h]) * 32768;
      for (int n = 0; n < N; n++) a += longint'(mc[h*N+n]) * longint'(fv[n]);
      hv[h] = sat16(a);
      if (hv[h] < 0) hv[h] = 0;
    end
    for (int o = 0; o < 2; o++) begin
      a = longint'(mc[OB+o]) * 32768;
      for (int h = 0; h < H; h++) a += longint'(mc[WO+o*H+h]) * longint'(hv[h]);
      if (o == 0) ei = sat16(a); else eq = sat16(a);
    end
  endtask

  function automatic logic [N*16-1:0] pack();
    logic [N*16-1:0] p;
    for (int n = 0; n < N; n++) p[n*16 +: 16] = fv[n];
    return p;
  endfunction

  task automatic wr(input int addr, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(addr); wr_data = d;
    if (addr < TOTAL) mc[addr] = d;
  endtask

  task automatic clear_all();
    for (int a = 0; a < TOTAL; a++) wr(a, 16'h0000);
  endtask

  task automatic run(input int mode, input string req);
    int cnt;
    model();
    @(negedge clk);
    wr_en = 0; in_feat = pack(); in_valid = 1;
    @(negedge clk);
    in_valid = 0; cnt = 1;
    chk(busy === 1'b1, "R6 busy after start", busy, 1);
    while (out_valid !== 1'b1 && cnt < 1000) begin
      if (cnt == 3 && mode == 1) begin in_feat = ~in_feat; in_valid = 1; end
      if (cnt == 3 && mode == 2) begin wr_en = 1; wr_addr = AW'(OB); wr_data = 16'h3000; end
      @(negedge clk);
      cnt++;
      in_valid = 0; wr_en = 0;
    end
    chk(cnt == LAT + 1, "R6 latency", cnt, LAT + 1);
    chk(busy === 1'b0, "R6 busy low at done", busy, 0);
    chk(out_i === ei, {req, " out_i"}, $signed(out_i), ei);
    chk(out_q === eq, {req, " out_q"}, $signed(out_q), eq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pulses;
    logic [15:0] hi, hq;
    for (int a = 0; a < TOTAL; a++) mc[a] = 0;
    for (int n = 0; n < N; n++) fv[n] = 16'(n * 1000 + 77);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 0 && out_valid === 0, "R1 flags", {busy, out_valid}, 0);
    chk(out_i === 0 && out_q === 0, "R1 outputs", {out_i, out_q}, 0);
    rst_n = 1;
    run(0, "R1 zero coefficients");

    // R2 map: hidden bias 1 and output weight (Q, hidden 1)
    clear_all();
    wr(HB + 1, 16'h2000);
    wr(WO + H + 1, 16'h4000);
    run(0, "R2 map");
    chk(out_q === 16'h1000, "R2 Q path", $signed(out_q), 16'h1000);
    chk(out_i === 16'h0000, "R2 I path", $signed(out_i), 0);
    wr(TOTAL + 1, 16'h7777);
    run(0, "R2 out of range write");

    // R3 rectified hidden layer
    clear_all();
    wr(HB + 0, 16'hC000);
    wr(HB + 1, 16'h2000);
    wr(WO + 0, 16'h4000);
    wr(WO + 1, 16'h4000);
    run(0, "R3 relu");
    chk(out_i === 16'h1000, "R3 relu clip", $signed(out_i), 16'h1000);
    // R4 linear output, negative passes
    wr(OB + 0, 16'hE000);
    wr(OB + 1, 16'h0100);
    run(0, "R4 linear");
    chk(out_i === 16'hF000, "R4 negative I", $signed(out_i), -4096);
    chk(out_q === 16'h0100, "R4 Q bias", $signed(out_q), 256);

    // R3 round half up
    clear_all();
    wr(0, 16'h0001);
    wr(WO + 0, 16'h7FFF);
    for (int n = 0; n < N; n++) fv[n] = 0;
    fv[0] = 16'h4000;
    run(0, "R3 rounding");
    chk(out_i === 16'h0001, "R3 round up", $signed(out_i), 1);

    // R5 saturation both signs
    clear_all();
    for (int a = 0; a < HB; a++) wr(a, 16'h7FFF);
    for (int h = 0; h < H; h++) begin wr(WO + h, 16'h7FFF); wr(WO + H + h, 16'h8000); end
    for (int n = 0; n < N; n++) fv[n] = 16'h7FFF;
    run(0, "R5 saturation");
    chk(out_i === 16'h7FFF, "R5 positive clamp", $signed(out_i), 32767);
    chk(out_q === 16'h8000, "R5 negative clamp", $signed(out_q), -32768);

    // R9 hold between pulses
    hi = out_i; hq = out_q;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(out_i === hi && out_q === hq && out_valid === 0, "R9 hold", {out_i, out_q}, {hi, hq});
    end

    // R3 R4 random sweep
    for (int r = 0; r < 160; r++) begin
      if (r % 8 == 0)
        for (int a = 0; a < TOTAL; a++) begin
          logic [15:0] v;
          v = 16'($urandom);
          if (r % 16 == 8) v = 16'($signed(v) >>> 2);
          wr(a, v);
        end
      for (int n = 0; n < N; n++) fv[n] = 16'($urandom);
      run(0, "R4 random sweep");
    end

    // R7 start strobe during busy
    for (int n = 0; n < N; n++) fv[n] = 16'($urandom);
    run(1, "R7 start ignored");
    pulses = 0;
    for (int c = 0; c < LAT + 4; c++) begin
      @(negedge clk);
      if (out_valid === 1'b1 || busy === 1'b1) pulses++;
    end
    chk(pulses == 0, "R7 no extra run", pulses, 0);

    // R8 write during busy
    wr(OB, 16'h0123);
    run(2, "R8 write ignored");
    run(0, "R8 coefficient kept");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule